// File: doc/BRIEF.md
# Thirty-Two Source Register-Mapped Interrupt Controller

This block collects up to thirty-two interrupt request lines and turns them into two processor-facing request outputs: a normal one and a critical one. Each line is first passed through a two-flop synchroniser. It is then judged either as a level or as an edge. The direction is chosen per line: high or low for a level, rising or falling for an edge. A qualifying event latches a pending flag in a status word.

Software uses a word-wide register port with an address, a read strobe, a write strobe and 32-bit data. It configures the sensing per line, the enable mask and the steering to the critical or normal output. To find work, it reads the status word filtered by the enable mask. It retires a request by writing ones to the matching status bits.

All per-source words place source `n` at bit `31-n`, so source 0 is the most significant bit. Vector generation and chaining of several controllers are not part of the block.

Top module: `sirq_ctrl`

## Requirements
- R1: After reset the enable, critical, polarity, trigger and status words all read zero and both request outputs are low, provided every input is held high.
- R2: In every per-source word, source n occupies bit 31-n. Source 0 is bit 31 and source 31 is bit 0.
- R3: A source whose trigger bit is 0 is level sensed. Its status bit is set in every cycle in which its synchronised input equals its polarity bit: 1 means active high, 0 means active low.
- R4: A source whose trigger bit is 1 is edge sensed. It sets its status bit once for each rising transition (polarity 1) or falling transition (polarity 0). A transition in the other direction, or a change of the configuration alone, sets nothing.
- R5: Writing the status word (offset 0x0) clears each bit written as 1 and leaves bits written as 0 unchanged. Writing all ones clears every pending flag.
- R6: A status clear on a level source has no lasting effect while its input is still at the active level, whether or not the source is enabled.
- R7: When a source sets its status bit in the same cycle that software clears it, the bit stays set.
- R8: Status bits latch whatever the enable word (offset 0x2) holds. The masked-status word (offset 0x6) reads status AND enable. Enabling a source that is already pending raises its output one cycle after the write.
- R9: The critical-select word (offset 0x3) steers each pending enabled source. A bit of 1 sends it to the critical output and 0 to the normal output. Each output is the registered OR of its share.
- R10: Polarity is at offset 0x4 and trigger at offset 0x5, both readable. Offsets 0x7, 0x8 and any unused offset read zero, and writes to them change no register.
- R11: An input transition shows in the status word three clock edges after it is applied, and on a request output one edge later. Read data is registered and appears one edge after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register word offset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| srcIn | input | 32 | Interrupt request lines, srcIn[n] is source n |
| irqNormal | output | 1 | Normal interrupt request |
| irqCritical | output | 1 | Critical interrupt request |

## Verification
Single sources are driven through rising and falling transitions under each polarity. This separates edges of the chosen direction from the opposite direction, and the MSB-first bit placement from a plain LSB-first one. A level source is held active while software clears it, both masked and unmasked, then released. This tells the sticky level behaviour apart from an ordinary write-one-to-clear. An edge is timed so that its set lands on the same edge as a clear, which shows that the set wins. A run of transitions counted edge by edge pins the three-stage latency to status and the extra stage to the outputs.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_CRIT   = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_POL    = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_TRIG   = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 4'h6;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_CRIT,
    SEL_POL,
    SEL_TRIG,
    SEL_MASKED
  } rdSel_e;

  typedef struct packed {
    logic   clrStat;
    logic   wrEnable;
    logic   wrCrit;
    logic   wrPol;
    logic   wrTrig;
    logic   rdStb;
    rdSel_e rdSel;
  } ctlStb_t;

endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
  parameter int   WIDTH   = 32,
  parameter int   STAGES  = 2,
  parameter logic RST_BIT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam logic [WIDTH-1:0] RST_WORD = {WIDTH{RST_BIT}};

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_WORD;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/sirq_ctrl_dec.sv
module sirq_ctrl_dec
  import sirq_pkg::*;
(
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStb_t           ctl
);

  always_comb begin
    ctl = '0;
    ctl.rdSel = SEL_NONE;
    if (wrEn) begin
      unique case (regAddr)
        OFS_STATUS: ctl.clrStat  = 1'b1;
        OFS_ENABLE: ctl.wrEnable = 1'b1;
        OFS_CRIT:   ctl.wrCrit   = 1'b1;
        OFS_POL:    ctl.wrPol    = 1'b1;
        OFS_TRIG:   ctl.wrTrig   = 1'b1;
        default:    ;
      endcase
    end
    if (rdEn) begin
      ctl.rdStb = 1'b1;
      unique case (regAddr)
        OFS_STATUS: ctl.rdSel = SEL_STATUS;
        OFS_ENABLE: ctl.rdSel = SEL_ENABLE;
        OFS_CRIT:   ctl.rdSel = SEL_CRIT;
        OFS_POL:    ctl.rdSel = SEL_POL;
        OFS_TRIG:   ctl.rdSel = SEL_TRIG;
        OFS_MASKED: ctl.rdSel = SEL_MASKED;
        default:    ctl.rdSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sirq_datapath.sv
module sirq_datapath
  import sirq_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStb_t            ctl,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcBits,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqNormal,
  output logic               irqCritical
);

  logic [NUM_SRC-1:0] syncd;
  logic [NUM_SRC-1:0] prevReg;
  logic [NUM_SRC-1:0] enReg, critReg, polReg, trigReg, statReg;
  logic [NUM_SRC-1:0] setVec, clrMask, statNext, maskedVec;
  logic [NUM_SRC-1:0] rdMux;

  sirq_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES),
    .RST_BIT(1'b1)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(srcBits),
    .syncOut(syncd)
  );

  // Per-source event detection: level match or directed transition.
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_detect
    logic lvlActive;
    logic edgeHit;
    always_comb begin
      lvlActive = (syncd[b] == polReg[b]);
      edgeHit   = polReg[b] ? (syncd[b] & ~prevReg[b])
                            : (~syncd[b] & prevReg[b]);
      setVec[b] = trigReg[b] ? edgeHit : lvlActive;
    end
  end

  always_comb begin
    clrMask   = ctl.clrStat ? wrData : '0;
    statNext  = (statReg & ~clrMask) | setVec;
    maskedVec = statReg & enReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevReg <= '1;
      statReg <= '0;
      enReg   <= '0;
      critReg <= '0;
      polReg  <= '0;
      trigReg <= '0;
    end else begin
      prevReg <= syncd;
      statReg <= statNext;
      if (ctl.wrEnable) enReg   <= wrData;
      if (ctl.wrCrit)   critReg <= wrData;
      if (ctl.wrPol)    polReg  <= wrData;
      if (ctl.wrTrig)   trigReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqNormal   <= 1'b0;
      irqCritical <= 1'b0;
    end else begin
      irqNormal   <= |(maskedVec & ~critReg);
      irqCritical <= |(maskedVec & critReg);
    end
  end

  always_comb begin
    unique case (ctl.rdSel)
      SEL_STATUS: rdMux = statReg;
      SEL_ENABLE: rdMux = enReg;
      SEL_CRIT:   rdMux = critReg;
      SEL_POL:    rdMux = polReg;
      SEL_TRIG:   rdMux = trigReg;
      SEL_MASKED: rdMux = maskedVec;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (ctl.rdStb) rdData <= rdMux;
  end

  AST_NO_PHANTOM_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statReg & ~$past(statReg) & ~$past(setVec)) == '0)) else $error("phantom set"); // R3
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrStat |=> ((statReg & $past(wrData & ~setVec)) == '0)) else $error("clear lost"); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((statReg & $past(setVec)) == $past(setVec))) else $error("set lost"); // R7
  AST_IRQ_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqNormal == |$past(statReg & enReg & ~critReg))) else $error("normal out"); // R9
  AST_IRQ_CRIT: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqCritical == |$past(statReg & enReg & critReg))) else $error("critical out"); // R9
  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrEnable |=> $stable(enReg)) else $error("enable moved"); // R10
  AST_CRIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrCrit |=> $stable(critReg)) else $error("crit moved"); // R10

endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqNormal,
  output logic               irqCritical
);

  localparam int TOP_BIT = NUM_SRC - 1;

  ctlStb_t            ctl;
  logic [NUM_SRC-1:0] srcBits;

  // Source n lands on register bit NUM_SRC-1-n.
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_order
    assign srcBits[TOP_BIT-n] = srcIn[n];
  end

  sirq_ctrl_dec u_dec (
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .regAddr(regAddr),
    .ctl    (ctl)
  );

  sirq_datapath #(
    .NUM_SRC    (NUM_SRC),
    .SYNC_STAGES(2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .wrData     (wrData),
    .srcBits    (srcBits),
    .rdData     (rdData),
    .irqNormal  (irqNormal),
    .irqCritical(irqCritical)
  );

endmodule

// File: tb/sirq_ctrl_tb.sv
module sirq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  regAddr;
  logic        rdEn, wrEn;
  logic [31:0] wrData, rdData, srcIn;
  logic        irqNormal, irqCritical;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rdItem_t;
  rdItem_t rdQ[$];
  rdItem_t curItem;

  always #2 clk = ~clk;

  sirq_ctrl u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .rdEn       (rdEn),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .rdData     (rdData),
    .srcIn      (srcIn),
    .irqNormal  (irqNormal),
    .irqCritical(irqCritical)
  );

  function automatic logic [31:0] bitOf(int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] e, string tag);
    rdItem_t it;
    it.exp = e; it.tag = tag;
    rdQ.push_back(it);
    regAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard once per read strobe.
  always @(posedge clk) begin
    if (rdEn) begin
      #1;
      if (rdQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R11: read with empty scoreboard, actual %h expected none", rdData);
      end else begin
        curItem = rdQ.pop_front();
        chk(curItem.tag, rdData, curItem.exp);
      end
    end
  end

  initial begin
    #(4 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; rdEn = 1'b0; wrEn = 1'b0; regAddr = '0; wrData = '0; srcIn = '1;
    idle(3);
    rstN = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 normal low", {31'b0, irqNormal}, 32'h0);
    chk("R1 critical low", {31'b0, irqCritical}, 32'h0);
    rd(4'h0, 32'h0, "R1 status");
    rd(4'h2, 32'h0, "R1 enable");
    rd(4'h3, 32'h0, "R1 crit");
    rd(4'h4, 32'h0, "R1 pol");
    rd(4'h5, 32'h0, "R1 trig");
    rd(4'h6, 32'h0, "R1 masked");

    // R4 configuration change alone sets nothing
    wr(4'h5, 32'hFFFF_FFFF);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h5, 32'hFFFF_FFFF, "R10 trig readback");
    rd(4'h4, 32'hFFFF_FFFF, "R10 pol readback");
    idle(4);
    rd(4'h0, 32'h0, "R4 config change no set");

    // R4 rising edge, R2 bit order
    srcIn[0] = 1'b0; idle(5);
    rd(4'h0, 32'h0, "R4 falling ignored under rising");
    srcIn[0] = 1'b1; idle(5);
    rd(4'h0, 32'h8000_0000, "R2 R4 source0 at bit31");
    rd(4'h6, 32'h0, "R8 masked while disabled");
    chk("R8 normal low while disabled", {31'b0, irqNormal}, 32'h0);

    // R8 enabling a pending source
    wr(4'h2, bitOf(0));
    idle(1);
    chk("R8 normal after enable", {31'b0, irqNormal}, 32'h1);
    chk("R9 critical low", {31'b0, irqCritical}, 32'h0);
    rd(4'h6, 32'h8000_0000, "R8 masked status");

    // R9 steering
    wr(4'h3, bitOf(0));
    idle(1);
    chk("R9 normal dropped", {31'b0, irqNormal}, 32'h0);
    chk("R9 critical raised", {31'b0, irqCritical}, 32'h1);

    // R5 write-one-to-clear
    wr(4'h0, bitOf(31));
    rd(4'h0, 32'h8000_0000, "R5 other bit untouched");
    wr(4'h0, bitOf(0));
    rd(4'h0, 32'h0, "R5 cleared");
    chk("R9 critical after clear", {31'b0, irqCritical}, 32'h0);

    // R4 falling edge on source 5
    wr(4'h4, ~bitOf(5));
    srcIn[5] = 1'b0; idle(5);
    rd(4'h0, bitOf(5), "R4 falling set");
    wr(4'h0, bitOf(5));
    srcIn[5] = 1'b1; idle(5);
    rd(4'h0, 32'h0, "R4 rising ignored under falling");

    // R3 R6 level source 31, masked
    wr(4'h5, ~bitOf(31));
    idle(4);
    rd(4'h0, bitOf(31), "R3 level high active");
    wr(4'h0, bitOf(31));
    rd(4'h0, bitOf(31), "R6 clear while active masked");
    srcIn[31] = 1'b0; idle(4);
    wr(4'h0, bitOf(31));
    rd(4'h0, 32'h0, "R6 clear after release");
    wr(4'h4, ~(bitOf(5) | bitOf(31)));
    idle(2);
    rd(4'h0, bitOf(31), "R3 level low active");
    srcIn[31] = 1'b1; idle(4);
    wr(4'h0, bitOf(31));
    rd(4'h0, 32'h0, "R3 level low released");

    // R6 level source while enabled
    wr(4'h2, bitOf(0) | bitOf(31));
    srcIn[31] = 1'b0; idle(4);
    wr(4'h0, bitOf(31));
    rd(4'h0, bitOf(31), "R6 clear while active enabled");
    chk("R9 normal from level", {31'b0, irqNormal}, 32'h1);
    srcIn[31] = 1'b1; idle(4);
    wr(4'h0, bitOf(31));
    wr(4'h2, bitOf(0));
    idle(1);
    chk("R9 normal after release", {31'b0, irqNormal}, 32'h0);

    // R11 latency: input to status 3 edges, to output 4
    srcIn[0] = 1'b0; idle(5);
    srcIn[0] = 1'b1;
    idle(3);
    chk("R11 output not yet", {31'b0, irqCritical}, 32'h0);
    idle(1);
    chk("R11 output on fourth edge", {31'b0, irqCritical}, 32'h1);
    wr(4'h0, bitOf(0));

    // R7 set and clear on same edge
    srcIn[0] = 1'b0; idle(5);
    wr(4'h0, 32'hFFFF_FFFF);
    srcIn[0] = 1'b1;
    idle(2);
    wr(4'h0, bitOf(0));
    rd(4'h0, bitOf(0), "R7 set wins");
    wr(4'h0, bitOf(0));
    rd(4'h0, 32'h0, "R7 later clear works");

    // R2 R8 R5 several pending, enable later, clear all
    srcIn[1] = 1'b0; srcIn[2] = 1'b0; idle(5);
    srcIn[1] = 1'b1; srcIn[2] = 1'b1; idle(5);
    rd(4'h0, bitOf(1) | bitOf(2), "R2 sources 1 and 2");
    wr(4'h2, bitOf(0) | bitOf(1));
    idle(1);
    chk("R8 enable pending raises normal", {31'b0, irqNormal}, 32'h1);
    rd(4'h6, bitOf(1), "R8 masked subset");
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0, "R5 all ones clear");
    chk("R5 normal after clear all", {31'b0, irqNormal}, 32'h0);

    // R10 reserved offsets
    wr(4'h7, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h1, 32'hFFFF_FFFF);
    rd(4'h7, 32'h0, "R10 offset 7 zero");
    rd(4'h8, 32'h0, "R10 offset 8 zero");
    rd(4'h1, 32'h0, "R10 unused offset zero");
    rd(4'h2, bitOf(0) | bitOf(1), "R10 enable untouched");
    rd(4'h3, bitOf(0), "R10 crit untouched");
    rd(4'h4, ~(bitOf(5) | bitOf(31)), "R10 pol untouched");
    rd(4'h0, 32'h0, "R10 status untouched");

    idle(2);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule